// File: doc/BRIEF.md
# Locality Register Access Filter

This block decides, for each decoded locality-addressed bus cycle, whether the addressed register may be touched. It receives the address phase from the bus framer: the cycle type, the locality number, a register identifier and the read/write direction. It also receives the vector of per-locality active flags. The block compares the addressed locality with that vector, giving one of three states: the addressed locality owns the flag, some other locality owns it, or no locality owns it. It then looks up the access right of the register for that state and direction.

An accepted cycle enables the SYNC handshake. For a read it also raises a read enable, and for a storing write it raises one bit of a per-register write strobe. A write to the interrupt status register stores nothing. Instead it produces a clear pulse for the pending interrupt. A rejected cycle is master-aborted: there is no SYNC, no read enable, no strobe and no clear. The decision is purely combinational, so it is ready long before the first SYNC slot.

Top module: `loc_access_filter`

## Requirements
- R1: A cycle with `cyc_is_loc`=0 (a plain IO cycle) is never accepted, in any direction, for any register or locality.
- R2: A locality value of 5, 6 or 7 does not name a locality and is always aborted. This covers the locality-none case.
- R3: When a cycle is not accepted, `sync_en`, `rd_en`, `wr_strobe` and `ists_clear` all stay 0.
- R4: When the addressed locality holds its flag, registers status (id 0), interrupt enable (id 1), interrupt vector (id 2), access (id 5) and configuration (id 8) accept both reads and writes. A valid storing write raises `wr_strobe` bit [id] and only that bit.
- R5: The interrupt status register (id 3) accepts reads in every state. A write is accepted only from the owning locality. It then raises `ists_clear` with `wr_strobe` all zero. The same write from another locality, or with no flag set, is aborted.
- R6: The interrupt capability register (id 4) accepts reads in every state and aborts every write.
- R7: The FIFO read role (id 6) accepts only reads, and the FIFO write role (id 7) accepts only writes. Both accept only from the owning locality. The wrong direction is aborted.
- R8: Status register and FIFO accesses are aborted when another locality holds the flag or when no flag is set.
- R9: The access register (id 5) accepts reads and writes in every locality state.
- R10: The hash-start register (id 9) aborts every read. A write is accepted from the owning locality and when no flag is set, and is aborted when another locality holds the flag.
- R11: Interrupt enable, interrupt vector and configuration accept reads in every state but accept writes only from the owning locality.
- R12: Register identifiers 10 to 15 are undefined and are always aborted.
- R13: `accept` gives the decision alone. `sync_en`, `rd_en`, `wr_strobe` and `ists_clear` are raised only while `cyc_valid`=1. Flag encoding: `active_loc[i]` set means locality i is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cyc_valid | input | 1 | Address phase is latched and valid |
| cyc_is_loc | input | 1 | 1 = locality-addressed cycle, 0 = plain IO cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_loc | input | 3 | Addressed locality number |
| cyc_reg | input | 4 | Register identifier (see requirements) |
| active_loc | input | 5 | Per-locality active flag, one-hot or zero |
| accept | output | 1 | Access decision for the presented cycle |
| sync_en | output | 1 | Allow the SYNC handshake for this cycle |
| rd_en | output | 1 | Read of the addressed register is performed |
| wr_strobe | output | 10 | One-hot store strobe, bit per register identifier |
| ists_clear | output | 1 | Clear pending interrupt status |

## Verification
The bench aims at the cases where a rule depends on all three locality states at once. One is the interrupt status write: a design that stored it would strobe a register instead of clearing. Another is the hash-start write with no flag set: a design that keyed only on ownership would abort it. The FIFO roles are driven in the wrong direction, where a design ignoring the role would perform a forbidden access. Out-of-range locality numbers and undefined identifiers are also driven, since a design with truncating compares would alias them onto real localities or registers. An exhaustive sweep then compares every combination of cycle type, direction, locality, identifier and flag state against a reference built from the requirements.

// File: rtl/loc_filter_pkg.sv
package loc_filter_pkg;

   typedef enum logic [1:0] {
      LS_OWN   = 2'd0,
      LS_OTHER = 2'd1,
      LS_NONE  = 2'd2,
      LS_BAD   = 2'd3
   } loc_state_e;

   localparam int unsigned RID_STS    = 0;
   localparam int unsigned RID_IEN    = 1;
   localparam int unsigned RID_IVEC   = 2;
   localparam int unsigned RID_ISTS   = 3;
   localparam int unsigned RID_ICAP   = 4;
   localparam int unsigned RID_ACCESS = 5;
   localparam int unsigned RID_FIFORD = 6;
   localparam int unsigned RID_FIFOWR = 7;
   localparam int unsigned RID_CFG    = 8;
   localparam int unsigned RID_HSTART = 9;
   localparam int unsigned RID_COUNT  = 10;

   typedef struct packed {
      logic rd_own;
      logic rd_other;
      logic rd_none;
      logic wr_own;
      logic wr_other;
      logic wr_none;
   } rights_t;

   function automatic rights_t rights_of(input int unsigned id, input bit hash_idle_wr);
      rights_t r;
      r = '0;
      case (id)
         RID_STS, RID_FIFORD, RID_FIFOWR: begin
            r.rd_own = (id != RID_FIFOWR);
            r.wr_own = (id != RID_FIFORD);
         end
         RID_IEN, RID_IVEC, RID_CFG: begin
            r.rd_own = 1'b1; r.rd_other = 1'b1; r.rd_none = 1'b1;
            r.wr_own = 1'b1;
         end
         RID_ISTS: begin
            r.rd_own = 1'b1; r.rd_other = 1'b1; r.rd_none = 1'b1;
            r.wr_own = 1'b1;
         end
         RID_ICAP: begin
            r.rd_own = 1'b1; r.rd_other = 1'b1; r.rd_none = 1'b1;
         end
         RID_ACCESS: begin
            r = '1;
         end
         RID_HSTART: begin
            r.wr_own  = 1'b1;
            r.wr_none = hash_idle_wr;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lf_loc_state.sv
module lf_loc_state
   import loc_filter_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned LOC_W   = 3
) (
   input  logic [LOC_W-1:0]   loc,
   input  logic [NUM_LOC-1:0] active,
   output loc_state_e         state
);
   localparam int unsigned CMP_W = LOC_W + 1;

   if (NUM_LOC > (1 << LOC_W)) begin : g_bad_loc_w
      $error("lf_loc_state: LOC_W too narrow for NUM_LOC");
   end

   logic [NUM_LOC-1:0] hit;
   logic               in_range;

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_hit
      assign hit[i] = active[i] && (loc == LOC_W'(i));
   end

   assign in_range = ({1'b0, loc} < CMP_W'(NUM_LOC));

   always_comb begin
      if (!in_range)        state = LS_BAD;
      else if (|hit)        state = LS_OWN;
      else if (active == '0) state = LS_NONE;
      else                  state = LS_OTHER;
   end

   always_comb begin
      if (!$isunknown({loc, active})) begin
         p_range_bad_r2: assert (in_range || state == LS_BAD)
            else $error("locality out of range not flagged");
         p_own_flag_r13: assert (state != LS_OWN || active[loc[LOC_W-1:0] % NUM_LOC])
            else $error("own state without flag");
      end
   end

endmodule

// File: rtl/lf_rights_rom.sv
module lf_rights_rom
   import loc_filter_pkg::*;
#(
   parameter int unsigned REG_W           = 4,
   parameter int unsigned NUM_REG         = 10,
   parameter bit          HASH_IDLE_WRITE = 1'b1
) (
   input  logic [REG_W-1:0] reg_id,
   output rights_t          rights
);
   localparam int unsigned ID_SPACE = 1 << REG_W;

   if (NUM_REG != RID_COUNT) begin : g_bad_count
      $error("lf_rights_rom: NUM_REG must match the register set");
   end
   if (ID_SPACE < NUM_REG) begin : g_bad_reg_w
      $error("lf_rights_rom: REG_W too narrow");
   end

   rights_t tbl [ID_SPACE];

   for (genvar i = 0; i < ID_SPACE; i++) begin : g_tbl
      if (i < NUM_REG) begin : g_def
         if (i == RID_HSTART && !HASH_IDLE_WRITE) begin : g_hash_strict
            assign tbl[i] = rights_of(i, 1'b0);
         end else begin : g_std
            assign tbl[i] = rights_of(i, HASH_IDLE_WRITE);
         end
      end else begin : g_undef
         assign tbl[i] = '0;
      end
   end

   assign rights = tbl[reg_id];

   always_comb begin
      if (!$isunknown(reg_id)) begin
         p_hash_wo_r10: assert (reg_id != REG_W'(RID_HSTART) ||
                                !(rights.rd_own || rights.rd_other || rights.rd_none))
            else $error("hash start readable");
         p_icap_ro_r6: assert (reg_id != REG_W'(RID_ICAP) ||
                               !(rights.wr_own || rights.wr_other || rights.wr_none))
            else $error("capability writable");
      end
   end

endmodule

// File: rtl/lf_strobe_dec.sv
module lf_strobe_dec #(
   parameter int unsigned REG_W   = 4,
   parameter int unsigned NUM_REG = 10
) (
   input  logic               en,
   input  logic [REG_W-1:0]   reg_id,
   output logic [NUM_REG-1:0] strobe
);
   for (genvar i = 0; i < NUM_REG; i++) begin : g_bit
      assign strobe[i] = en && (reg_id == REG_W'(i));
   end

   always_comb begin
      if (!$isunknown({en, reg_id})) begin
         p_strobe_onehot_r4: assert ($onehot0(strobe))
            else $error("more than one strobe");
      end
   end

endmodule

// File: rtl/loc_access_filter.sv
module loc_access_filter
   import loc_filter_pkg::*;
#(
   parameter int unsigned NUM_LOC         = 5,
   parameter int unsigned LOC_W           = 3,
   parameter int unsigned REG_W           = 4,
   parameter int unsigned NUM_REG         = 10,
   parameter bit          HASH_IDLE_WRITE = 1'b1
) (
   input  logic               cyc_valid,
   input  logic               cyc_is_loc,
   input  logic               cyc_write,
   input  logic [LOC_W-1:0]   cyc_loc,
   input  logic [REG_W-1:0]   cyc_reg,
   input  logic [NUM_LOC-1:0] active_loc,
   output logic               accept,
   output logic               sync_en,
   output logic               rd_en,
   output logic [NUM_REG-1:0] wr_strobe,
   output logic               ists_clear
);
   loc_state_e st;
   rights_t    rt;
   logic       rd_ok, wr_ok;
   logic       is_ists, store_en;

   lf_loc_state #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) i_state (
      .loc    (cyc_loc),
      .active (active_loc),
      .state  (st)
   );

   lf_rights_rom #(.REG_W(REG_W), .NUM_REG(NUM_REG),
                   .HASH_IDLE_WRITE(HASH_IDLE_WRITE)) i_rom (
      .reg_id (cyc_reg),
      .rights (rt)
   );

   always_comb begin
      case (st)
         LS_OWN:   begin rd_ok = rt.rd_own;   wr_ok = rt.wr_own;   end
         LS_OTHER: begin rd_ok = rt.rd_other; wr_ok = rt.wr_other; end
         LS_NONE:  begin rd_ok = rt.rd_none;  wr_ok = rt.wr_none;  end
         default:  begin rd_ok = 1'b0;        wr_ok = 1'b0;        end
      endcase
   end

   assign accept     = cyc_is_loc && (cyc_write ? wr_ok : rd_ok);
   assign sync_en    = cyc_valid && accept;
   assign rd_en      = sync_en && !cyc_write;
   assign is_ists    = (cyc_reg == REG_W'(RID_ISTS));
   assign store_en   = sync_en && cyc_write && !is_ists;
   assign ists_clear = sync_en && cyc_write && is_ists;

   lf_strobe_dec #(.REG_W(REG_W), .NUM_REG(NUM_REG)) i_strobe (
      .en     (store_en),
      .reg_id (cyc_reg),
      .strobe (wr_strobe)
   );

   always_comb begin
      if (!$isunknown({cyc_valid, cyc_is_loc, cyc_write, cyc_loc, cyc_reg, active_loc})) begin
         p_io_reject_r1: assert (cyc_is_loc || !accept)
            else $error("plain IO cycle accepted");
         p_abort_quiet_r3: assert (sync_en || (!rd_en && wr_strobe == '0 && !ists_clear))
            else $error("side effect on aborted cycle");
         p_clear_owner_r5: assert (!ists_clear || (st == LS_OWN && cyc_write))
            else $error("status clear from non-owner");
         p_valid_gate_r13: assert (cyc_valid || !sync_en)
            else $error("sync without valid cycle");
      end
   end

endmodule

// File: tb/test_loc_access_filter.sv
module test_loc_access_filter;

   logic       clk = 1'b0;
   logic       cyc_valid = 1'b0, cyc_is_loc = 1'b0, cyc_write = 1'b0;
   logic [2:0] cyc_loc = '0;
   logic [3:0] cyc_reg = '0;
   logic [4:0] active_loc = '0;
   logic       accept, sync_en, rd_en, ists_clear;
   logic [9:0] wr_strobe;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   loc_access_filter i_loc_access_filter (
      .cyc_valid(cyc_valid), .cyc_is_loc(cyc_is_loc), .cyc_write(cyc_write),
      .cyc_loc(cyc_loc), .cyc_reg(cyc_reg), .active_loc(active_loc),
      .accept(accept), .sync_en(sync_en), .rd_en(rd_en),
      .wr_strobe(wr_strobe), .ists_clear(ists_clear)
   );

   // {is_loc, write, loc, reg, active, exp_accept, exp_clear, req}
   localparam int NV = 28;
   localparam logic [19:0] VEC [NV] = '{
      {1'b0,1'b0,3'd0,4'd0, 5'b00001,1'b0,1'b0,4'd1},  // R1 IO read
      {1'b0,1'b1,3'd0,4'd5, 5'b00000,1'b0,1'b0,4'd1},  // R1 IO write
      {1'b1,1'b0,3'd5,4'd5, 5'b00000,1'b0,1'b0,4'd2},  // R2 loc 5
      {1'b1,1'b1,3'd7,4'd5, 5'b00000,1'b0,1'b0,4'd2},  // R2 loc 7
      {1'b1,1'b1,3'd2,4'd0, 5'b00100,1'b1,1'b0,4'd4},  // R4 own status wr
      {1'b1,1'b1,3'd2,4'd1, 5'b00100,1'b1,1'b0,4'd4},  // R4 own ien wr
      {1'b1,1'b0,3'd2,4'd2, 5'b00100,1'b1,1'b0,4'd4},  // R4 own ivec rd
      {1'b1,1'b1,3'd2,4'd8, 5'b00100,1'b1,1'b0,4'd4},  // R4 own cfg wr
      {1'b1,1'b1,3'd1,4'd3, 5'b00010,1'b1,1'b1,4'd5},  // R5 own ists wr
      {1'b1,1'b1,3'd1,4'd3, 5'b00100,1'b0,1'b0,4'd5},  // R5 other ists wr
      {1'b1,1'b0,3'd1,4'd3, 5'b00000,1'b1,1'b0,4'd5},  // R5 none ists rd
      {1'b1,1'b1,3'd0,4'd4, 5'b00001,1'b0,1'b0,4'd6},  // R6 icap wr own
      {1'b1,1'b0,3'd0,4'd4, 5'b00010,1'b1,1'b0,4'd6},  // R6 icap rd other
      {1'b1,1'b0,3'd3,4'd6, 5'b01000,1'b1,1'b0,4'd7},  // R7 rd role rd
      {1'b1,1'b1,3'd3,4'd6, 5'b01000,1'b0,1'b0,4'd7},  // R7 rd role wr
      {1'b1,1'b1,3'd3,4'd7, 5'b01000,1'b1,1'b0,4'd7},  // R7 wr role wr
      {1'b1,1'b0,3'd3,4'd7, 5'b01000,1'b0,1'b0,4'd7},  // R7 wr role rd
      {1'b1,1'b0,3'd0,4'd0, 5'b10000,1'b0,1'b0,4'd8},  // R8 status other
      {1'b1,1'b1,3'd0,4'd7, 5'b00000,1'b0,1'b0,4'd8},  // R8 fifo none
      {1'b1,1'b1,3'd4,4'd5, 5'b00001,1'b1,1'b0,4'd9},  // R9 access other wr
      {1'b1,1'b0,3'd4,4'd5, 5'b00000,1'b1,1'b0,4'd9},  // R9 access none rd
      {1'b1,1'b0,3'd0,4'd9, 5'b00001,1'b0,1'b0,4'd10}, // R10 hash rd own
      {1'b1,1'b1,3'd0,4'd9, 5'b00000,1'b1,1'b0,4'd10}, // R10 hash wr none
      {1'b1,1'b1,3'd0,4'd9, 5'b00010,1'b0,1'b0,4'd10}, // R10 hash wr other
      {1'b1,1'b0,3'd1,4'd1, 5'b00001,1'b1,1'b0,4'd11}, // R11 ien rd other
      {1'b1,1'b1,3'd1,4'd8, 5'b00000,1'b0,1'b0,4'd11}, // R11 cfg wr none
      {1'b1,1'b0,3'd0,4'd12,5'b00001,1'b0,1'b0,4'd12}, // R12 id 12
      {1'b1,1'b1,3'd0,4'd15,5'b00001,1'b0,1'b0,4'd12}  // R12 id 15
   };

   // expected {accept, clear} from the requirements
   function automatic logic [1:0] ref_dec(logic io_n, logic wr, logic [2:0] l,
                                          logic [3:0] r, logic [4:0] a);
      int s; // 0 own 1 other 2 none 3 bad
      logic ok;
      if (l > 3'd4)         s = 3;
      else if (a[l])        s = 0;
      else if (a == 5'd0)   s = 2;
      else                  s = 1;
      ok = 1'b0;
      if (io_n && s != 3) begin
         case (r)
            4'd0, 4'd6, 4'd7: ok = (s == 0) && (r == 4'd0 || (r == 4'd6) == !wr);
            4'd1, 4'd2, 4'd3, 4'd8: ok = wr ? (s == 0) : 1'b1;
            4'd4: ok = !wr;
            4'd5: ok = 1'b1;
            4'd9: ok = wr && (s != 1);
            default: ok = 1'b0;
         endcase
      end
      return {ok, ok && wr && r == 4'd3};
   endfunction

   task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: {acc,sync,rd,strobe,clr} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply_and_check(string tag, logic v, logic io_n, logic wr,
                                  logic [2:0] l, logic [3:0] r, logic [4:0] a);
      logic [1:0] e;
      logic [9:0] es;
      @(negedge clk);
      cyc_valid = v; cyc_is_loc = io_n; cyc_write = wr;
      cyc_loc = l; cyc_reg = r; active_loc = a;
      #5;
      e  = ref_dec(io_n, wr, l, r, a);
      es = (v && e[1] && wr && r != 4'd3 && r < 4'd10) ? (10'd1 << r) : 10'd0;
      check(tag, {accept, sync_en, rd_en, wr_strobe, ists_clear},
            {e[1], v && e[1], v && e[1] && !wr, es, v && e[0]});
   endtask

   initial begin
      // reset / idle state: nothing valid, nothing performed (R13)
      @(negedge clk); #5;
      check("R13 idle", {1'b0, sync_en, rd_en, wr_strobe, ists_clear}, 14'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         logic [9:0]  es;
         v = VEC[i];
         @(negedge clk);
         cyc_valid = 1'b1; cyc_is_loc = v[19]; cyc_write = v[18];
         cyc_loc = v[17:15]; cyc_reg = v[14:11]; active_loc = v[10:6];
         #5;
         es = (v[5] && v[18] && v[14:11] != 4'd3) ? (10'd1 << v[14:11]) : 10'd0;
         check($sformatf("R%0d vec%0d", v[3:0], i),
               {accept, sync_en, rd_en, wr_strobe, ists_clear},
               {v[5], v[5], v[5] && !v[18], es, v[4]});
         if (!v[5])
            check($sformatf("R3 vec%0d quiet", i),
                  {1'b0, sync_en, rd_en, wr_strobe, ists_clear}, 14'd0);
      end

      // R13: accepted decision but no valid cycle
      apply_and_check("R13 access no valid", 1'b0, 1'b1, 1'b1, 3'd0, 4'd5, 5'b0);
      apply_and_check("R13 ists no valid", 1'b0, 1'b1, 1'b1, 3'd1, 4'd3, 5'b00010);

      // exhaustive sweep against the reference
      for (int io = 0; io < 2; io++)
         for (int w = 0; w < 2; w++)
            for (int l = 0; l < 8; l++)
               for (int r = 0; r < 16; r++)
                  for (int a = 0; a < 6; a++)
                     apply_and_check($sformatf("R12 sweep io%0d w%0d l%0d r%0d a%0d", io, w, l, r, a),
                                     1'b1, io[0], w[0], l[2:0], r[3:0],
                                     (a == 5) ? 5'd0 : (5'd1 << a));
      done = 1'b1;
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               n_checks++;
               n_errors++;
               $display("FAIL R13 watchdog: actual=hung expected=done");
            end
         end
         wait (done);
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule